// File: doc/BRIEF.md
# Packed-BCD Time-of-Day and Date Counter

This block keeps a 24-hour time of day and a calendar date as packed BCD words. A slow clock is divided in two cascaded stages, a short first divider feeding a wide second divider, to produce one calendar advance per period. Each advance adds one second and ripples carries through minutes, hours, day of month, month and year. The weekday runs alongside the day of month.

Software or a setup sequencer raises the freeze input, loads the time and date words through the parallel load strobes, programs both divider reload values, and then drops the freeze input. Both dividers restart from their reload values at that moment, so the first advance lands exactly one full period after release. Reading the two outputs gives the live calendar at any time.

Top module: `bcd_calendar`

## Requirements
- R1: After reset both the time output and the date output are all zero.
- R2: With freeze low, the calendar advances once every (first reload + 1) × (second reload + 1) clock cycles. The first advance comes exactly that many rising edges after freeze is sampled low, because both dividers restart from their reload values on release.
- R3: The time word carries BCD seconds in bits 6:0, BCD minutes in bits 14:8 and BCD hours in bits 21:16. Seconds and minutes each roll from 59 to 00 and carry into the next field.
- R4: Hours count 00 to 23. An advance at 23:59:59 gives 00:00:00 and moves the date on by one day.
- R5: The date word carries BCD day in bits 5:0, BCD month in bits 12:8, weekday in bits 15:13 and BCD year in bits 23:16. Day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02.
- R6: In month 02, day wraps after 29 when the two-digit year is a multiple of 4 (00 included), and after 28 otherwise.
- R7: A day wrap in month 12 gives month 01 and advances the year. Year 99 wraps to 00.
- R8: The weekday advances by one on each day carry and wraps from 7 to 1.
- R9: While freeze is high, the time and date outputs hold their values whatever the divider state.
- R10: A load strobe writes its word only while freeze is high. With freeze low the strobe has no effect on either output.
- R11: Loading all-zero time and date words is legal. A later advance counts the seconds up from 00 and leaves the date untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock that drives the dividers and the calendar |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Stops the dividers and the calendar and enables loading |
| div_a_reload | input | 7 | Reload value of the first divider stage |
| div_b_reload | input | 15 | Reload value of the second divider stage |
| time_wr | input | 1 | Strobe that loads time_in while frozen |
| time_in | input | 22 | Packed BCD time word to load |
| date_wr | input | 1 | Strobe that loads date_in while frozen |
| date_in | input | 24 | Packed BCD date word to load |
| time_out | output | 22 | Live packed BCD time word |
| date_out | output | 24 | Live packed BCD date word |

## Verification
The bound checker checks five things on every cycle:
- both words stay unchanged while frozen;
- a strobe taken while frozen writes the masked word;
- seconds only stay, step by one BCD count or return to 00;
- 23:59:59 only holds or becomes midnight;
- the date moves only at a midnight rollover, and year 99 only holds or becomes 00.

Month lengths, leap-year February, weekday wrap, the exact divider period and the no-effect of strobes outside freeze depend on the values loaded. Only the bench scenarios show them, through a table of one-advance vectors and directed timing tests.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

   localparam int TIME_W = 22;
   localparam int DATE_W = 24;

   // usable bits of each packed word
   localparam logic [TIME_W-1:0] TIME_MASK = 22'h3F7F7F;
   localparam logic [DATE_W-1:0] DATE_MASK = 24'hFFFF3F;

   // field positions (low bit) and widths
   localparam int SEC_LO = 0;
   localparam int MIN_LO = 8;
   localparam int HR_LO  = 16;
   localparam int DAY_LO = 0;
   localparam int MON_LO = 8;
   localparam int WD_LO  = 13;
   localparam int YR_LO  = 16;

   // one BCD count up on a two-digit value
   function automatic logic [7:0] bcd_up(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // two-digit BCD year divisible by four
   function automatic logic bcd_leap(input logic [7:0] y);
      logic odd_tens;
      odd_tens = y[4];
      if (odd_tens) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else          return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         freeze,
   input  logic         step,
   input  logic [W-1:0] reload,
   output logic         tick
);
   logic [W-1:0] cnt_q;

   assign tick = step && !freeze && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (freeze)       cnt_q <= reload;
      else if (step) begin
         if (cnt_q == '0)    cnt_q <= reload;
         else                cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/cal_time_next.sv
module cal_time_next
   import bcd_calendar_pkg::*;
(
   input  logic [TIME_W-1:0] cur,
   output logic [TIME_W-1:0] nxt,
   output logic              day_carry
);
   logic [7:0] sec, mnt, hr;
   logic [7:0] sec_n, mnt_n, hr_n;
   logic       sec_wrap, min_wrap, hr_wrap;

   assign sec = {1'b0, cur[SEC_LO +: 7]};
   assign mnt = {1'b0, cur[MIN_LO +: 7]};
   assign hr  = {2'b0, cur[HR_LO  +: 6]};

   assign sec_wrap = (sec == 8'h59);
   assign min_wrap = sec_wrap && (mnt == 8'h59);
   assign hr_wrap  = min_wrap && (hr == 8'h23);

   always_comb begin
      sec_n = sec_wrap ? 8'h00 : bcd_up(sec);
      mnt_n = mnt;
      hr_n  = hr;
      if (sec_wrap) mnt_n = (mnt == 8'h59) ? 8'h00 : bcd_up(mnt);
      if (min_wrap) hr_n  = (hr == 8'h23) ? 8'h00 : bcd_up(hr);
   end

   assign nxt       = {hr_n[5:0], 1'b0, mnt_n[6:0], 1'b0, sec_n[6:0]};
   assign day_carry = hr_wrap;
endmodule

// File: rtl/cal_date_next.sv
module cal_date_next
   import bcd_calendar_pkg::*;
(
   input  logic [DATE_W-1:0] cur,
   output logic [DATE_W-1:0] nxt
);
   logic [7:0] day, mon, yr, last_day;
   logic [2:0] wd, wd_n;
   logic [7:0] day_n, mon_n, yr_n;
   logic       day_wrap, mon_wrap;

   assign day = {2'b0, cur[DAY_LO +: 6]};
   assign mon = {3'b0, cur[MON_LO +: 5]};
   assign wd  = cur[WD_LO +: 3];
   assign yr  = cur[YR_LO +: 8];

   always_comb begin
      case (mon)
         8'h02:                      last_day = bcd_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
         default:                    last_day = 8'h31;
      endcase
   end

   assign day_wrap = (day == last_day);
   assign mon_wrap = day_wrap && (mon == 8'h12);

   always_comb begin
      day_n = day_wrap ? 8'h01 : bcd_up(day);
      mon_n = mon;
      yr_n  = yr;
      if (day_wrap) mon_n = (mon == 8'h12) ? 8'h01 : bcd_up(mon);
      if (mon_wrap) yr_n  = (yr == 8'h99) ? 8'h00 : bcd_up(yr);
      wd_n = (wd == 3'd7) ? 3'd1 : wd + 3'd1;
   end

   assign nxt = {yr_n, wd_n, mon_n[4:0], 2'b00, day_n[5:0]};
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import bcd_calendar_pkg::*;
#(
   parameter int DIV_A_W = 7,
   parameter int DIV_B_W = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               freeze,
   input  logic [DIV_A_W-1:0] div_a_reload,
   input  logic [DIV_B_W-1:0] div_b_reload,
   input  logic               time_wr,
   input  logic [TIME_W-1:0]  time_in,
   input  logic               date_wr,
   input  logic [DATE_W-1:0]  date_in,
   output logic [TIME_W-1:0]  time_out,
   output logic [DATE_W-1:0]  date_out
);
   localparam int CHAIN_W = DIV_A_W + DIV_B_W;

   generate
      if (DIV_A_W < 1 || DIV_B_W < 1) begin : g_bad_div
         $error("bcd_calendar: divider widths must be positive");
      end
      if (CHAIN_W > 32) begin : g_bad_chain
         $error("bcd_calendar: divider chain wider than 32 bits");
      end
   endgenerate

   logic a_tick, adv;
   logic [TIME_W-1:0] time_q, time_nx;
   logic [DATE_W-1:0] date_q, date_nx;
   logic day_carry;

   cal_divider #(.W(DIV_A_W)) u_div_a (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .step(1'b1),
      .reload(div_a_reload), .tick(a_tick)
   );

   cal_divider #(.W(DIV_B_W)) u_div_b (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .step(a_tick),
      .reload(div_b_reload), .tick(adv)
   );

   cal_time_next u_tnext (.cur(time_q), .nxt(time_nx), .day_carry(day_carry));
   cal_date_next u_dnext (.cur(date_q), .nxt(date_nx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q <= '0;
         date_q <= '0;
      end else if (freeze) begin
         if (time_wr) time_q <= time_in & TIME_MASK;
         if (date_wr) date_q <= date_in & DATE_MASK;
      end else if (adv) begin
         time_q <= time_nx;
         if (day_carry) date_q <= date_nx;
      end
   end

   assign time_out = time_q;
   assign date_out = date_q;
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
   import bcd_calendar_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              freeze,
   input logic              time_wr,
   input logic [TIME_W-1:0] time_in,
   input logic              date_wr,
   input logic [TIME_W-1:0] time_out,
   input logic [DATE_W-1:0] date_out
);
   logic [7:0] sec;
   assign sec = {1'b0, time_out[6:0]};

   AST_FROZEN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !time_wr && !date_wr) |=> ($stable(time_out) && $stable(date_out))); // R9

   AST_TIME_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && time_wr) |=> (time_out == ($past(time_in) & TIME_MASK))); // R10

   AST_SEC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && $past(rst_n)) |=> ((sec == $past(sec)) || (sec == 8'h00) ||
                      (sec == bcd_up($past(sec))))); // R3

   AST_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && time_out == 22'h235959) |=>
      ((time_out == 22'h235959) || (time_out == 22'h000000))); // R4

   AST_DATE_ONLY_AT_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && time_out != 22'h235959) |=> $stable(date_out)); // R4

   AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && date_out[23:16] == 8'h99) |=>
      ((date_out[23:16] == 8'h99) || (date_out[23:16] == 8'h00))); // R7
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
   .clk(clk), .rst_n(rst_n), .freeze(freeze), .time_wr(time_wr),
   .time_in(time_in), .date_wr(date_wr), .time_out(time_out), .date_out(date_out)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b1;
   logic [6:0]  div_a_reload = 7'd1;
   logic [14:0] div_b_reload = 15'd1;
   logic        time_wr = 1'b0;
   logic [21:0] time_in = '0;
   logic        date_wr = 1'b0;
   logic [23:0] date_in = '0;
   logic [21:0] time_out;
   logic [23:0] date_out;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   bcd_calendar uut (
      .clk(clk), .rst_n(rst_n), .freeze(freeze),
      .div_a_reload(div_a_reload), .div_b_reload(div_b_reload),
      .time_wr(time_wr), .time_in(time_in), .date_wr(date_wr), .date_in(date_in),
      .time_out(time_out), .date_out(date_out)
   );

   function automatic logic [21:0] mkt(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      return {h[5:0], 1'b0, m[6:0], 1'b0, s[6:0]};
   endfunction

   function automatic logic [23:0] mkd(input logic [7:0] d, input logic [7:0] mo,
                                       input logic [2:0] w, input logic [7:0] y);
      return {y, w, mo[4:0], 2'b00, d[5:0]};
   endfunction

   typedef struct packed {
      logic [3:0]  req;
      logic [21:0] ti;
      logic [23:0] di;
      logic [21:0] te;
      logic [23:0] de;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{4'd3,  mkt(8'h12,8'h34,8'h56), mkd(8'h15,8'h03,3'd3,8'h24), mkt(8'h12,8'h34,8'h57), mkd(8'h15,8'h03,3'd3,8'h24)}, // R3
      '{4'd3,  mkt(8'h00,8'h00,8'h59), mkd(8'h01,8'h01,3'd1,8'h20), mkt(8'h00,8'h01,8'h00), mkd(8'h01,8'h01,3'd1,8'h20)}, // R3
      '{4'd3,  mkt(8'h09,8'h59,8'h59), mkd(8'h01,8'h01,3'd1,8'h20), mkt(8'h10,8'h00,8'h00), mkd(8'h01,8'h01,3'd1,8'h20)}, // R3
      '{4'd7,  mkt(8'h23,8'h59,8'h59), mkd(8'h31,8'h12,3'd7,8'h99), mkt(8'h00,8'h00,8'h00), mkd(8'h01,8'h01,3'd1,8'h00)}, // R7 R8 R4
      '{4'd6,  mkt(8'h23,8'h59,8'h59), mkd(8'h28,8'h02,3'd2,8'h23), mkt(8'h00,8'h00,8'h00), mkd(8'h01,8'h03,3'd3,8'h23)}, // R6
      '{4'd6,  mkt(8'h23,8'h59,8'h59), mkd(8'h28,8'h02,3'd2,8'h24), mkt(8'h00,8'h00,8'h00), mkd(8'h29,8'h02,3'd3,8'h24)}, // R6
      '{4'd6,  mkt(8'h23,8'h59,8'h59), mkd(8'h29,8'h02,3'd3,8'h24), mkt(8'h00,8'h00,8'h00), mkd(8'h01,8'h03,3'd4,8'h24)}, // R6
      '{4'd6,  mkt(8'h23,8'h59,8'h59), mkd(8'h28,8'h02,3'd5,8'h00), mkt(8'h00,8'h00,8'h00), mkd(8'h29,8'h02,3'd6,8'h00)}, // R6
      '{4'd6,  mkt(8'h23,8'h59,8'h59), mkd(8'h28,8'h02,3'd6,8'h12), mkt(8'h00,8'h00,8'h00), mkd(8'h29,8'h02,3'd7,8'h12)}, // R6
      '{4'd5,  mkt(8'h23,8'h59,8'h59), mkd(8'h30,8'h04,3'd4,8'h21), mkt(8'h00,8'h00,8'h00), mkd(8'h01,8'h05,3'd5,8'h21)}, // R5
      '{4'd5,  mkt(8'h23,8'h59,8'h59), mkd(8'h30,8'h05,3'd6,8'h21), mkt(8'h00,8'h00,8'h00), mkd(8'h31,8'h05,3'd7,8'h21)}, // R5
      '{4'd7,  mkt(8'h23,8'h59,8'h59), mkd(8'h31,8'h12,3'd2,8'h45), mkt(8'h00,8'h00,8'h00), mkd(8'h01,8'h01,3'd3,8'h46)}  // R7
   };

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
      end
   endtask

   task automatic load_words(input logic [21:0] t, input logic [23:0] d);
      time_in = t; date_in = d; time_wr = 1'b1; date_wr = 1'b1;
      @(posedge clk); #1;
      time_wr = 1'b0; date_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 time", {2'b0, time_out}, 24'h0);
      chk("R1 date", date_out, 24'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // table walk: one advance per vector, period 4 cycles
      for (int i = 0; i < NV; i++) begin
         freeze = 1'b1;
         load_words(VECS[i].ti, VECS[i].di);
         freeze = 1'b0;
         repeat (4) @(posedge clk);
         #1;
         freeze = 1'b1;
         chk($sformatf("R%0d vec%0d time", VECS[i].req, i), {2'b0, time_out}, {2'b0, VECS[i].te});
         chk($sformatf("R%0d vec%0d date", VECS[i].req, i), date_out, VECS[i].de);
      end

      // R2 and R11: period 3*4 = 12 cycles, zero words loaded
      div_a_reload = 7'd2;
      div_b_reload = 15'd3;
      load_words('0, '0);
      @(posedge clk); #1;
      freeze = 1'b0;
      repeat (11) @(posedge clk);
      #1;
      chk("R2 before period", {2'b0, time_out}, 24'h0);
      @(posedge clk); #1;
      chk("R2 first advance", {2'b0, time_out}, 24'h000001);
      repeat (12) @(posedge clk);
      #1;
      chk("R11 second advance", {2'b0, time_out}, 24'h000002);
      chk("R11 date untouched", date_out, 24'h0);

      // R9: frozen for many periods
      freeze = 1'b1;
      repeat (40) @(posedge clk);
      #1;
      chk("R9 time held", {2'b0, time_out}, 24'h000002);
      chk("R9 date held", date_out, 24'h0);

      // R10: strobes with freeze low do nothing
      freeze = 1'b0;
      time_in = mkt(8'h23, 8'h59, 8'h59);
      date_in = mkd(8'h31, 8'h12, 3'd7, 8'h99);
      time_wr = 1'b1; date_wr = 1'b1;
      @(posedge clk); #1;
      time_wr = 1'b0; date_wr = 1'b0;
      freeze = 1'b1;
      chk("R10 time ignored", {2'b0, time_out}, 24'h000002);
      chk("R10 date ignored", date_out, 24'h0);

      // R2: restart on release after partial count
      freeze = 1'b0;
      repeat (12) @(posedge clk);
      #1;
      freeze = 1'b1;
      chk("R2 restart period", {2'b0, time_out}, 24'h000003);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule